// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single 16-bit counting channel of the kind found in a three-channel interval timer. The block advances on a clock-enable pulse (`tick_i`) that stands for the fixed counter input clock. A load strobe captures a new initial count together with a mode number. From then on the channel counts according to that mode and produces two results: a live count value and an OUT waveform whose shape depends on the mode.

A gate input takes one of two roles. In the gated modes (0 and 4) it pauses counting while it is low. In the retriggerable modes (1, 2, 3 and 5) its rising edge restarts the period from the initial count. Bus decoding, byte sequencing, latching and BCD arithmetic belong elsewhere. The BCD flag is accepted and has no effect on counting.

Top module: `pit_channel`

## Requirements
- R1: One cycle after `load_i` is high, `count_o` equals `load_val_i`, and the period restarts from that point. A load value of 0 stands for 65536 and shows as 0x0000. A load takes priority over a tick or a gate edge in the same cycle.
- R2: After reset, `count_o` is 0x0000 (count 65536, mode 0) and `out_o` is low.
- R3: Mode 0 (`mode_i`=0). `count_o` is the initial count minus the elapsed ticks, modulo 2^16. `out_o` goes high on the tick where the elapsed ticks reach the count and stays high until the next load. While `gate_i` is low, ticks are not counted.
- R4: Mode 1 gives the same count and OUT waveform as mode 0. A rising edge on `gate_i` restarts the elapsed count at 0, and the gate level otherwise has no effect.
- R5: Mode 2. `count_o` is the initial count minus (elapsed mod initial). `out_o` is high for exactly one tick period after each tick where the elapsed count is a nonzero multiple of the initial count. A gate rising edge restarts the period.
- R6: Mode 3. With phase p = elapsed mod initial and h = (initial+1)/2, `out_o` is high while p < h and low otherwise. `count_o` is the initial count minus 2·p during the high half and minus 2·(p−h) during the low half. A gate rising edge restarts the period.
- R7: Mode 4. `out_o` is high only between the tick where the elapsed count equals the initial count and the next counted tick. The count follows the rule of R3, and a low gate stops counting.
- R8: Mode 5 strobes like mode 4, but a gate rising edge restarts the elapsed count at 0 and the gate level does not pause counting.
- R9: Mode codes 6 and 7 behave as modes 2 and 3.
- R10: `bcd_i` has no effect: counting is always binary.
- R11: In a cycle without `tick_i`, and without a load or a restart, neither `count_o` nor `out_o` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter input clock enable, one cycle per count |
| gate_i | input | 1 | Gate: level enable or edge retrigger, depending on the mode |
| load_i | input | 1 | Load strobe for a new initial count and mode |
| load_val_i | input | 16 | Initial count (0 means 65536) |
| mode_i | input | 3 | Counting mode, 0 to 7 |
| bcd_i | input | 1 | BCD flag, accepted with no effect |
| count_o | output | 16 | Live count value |
| out_o | output | 1 | Mode-dependent OUT waveform |

## Verification
All state of the channel sits in the phase counter, the sticky terminal flag, the strobe flag, the stored initial count and the stored mode. Each of these reaches `count_o` or `out_o` within the cycle after a counted tick. A wrong phase therefore shows as a wrong count on the next counted tick. A wrong terminal or strobe flag shows as an OUT edge one tick early, one tick late, or a strobe that lasts too long. A wrong mode decode or gate edge detect shows as a missing restart or as a pause that should not happen, within one tick of the gate change.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } mode_e;

  // codes 6 and 7 alias 2 and 3
  function automatic mode_e fold_mode(input logic [2:0] m);
    if (m[1]) return mode_e'({1'b0, m[1:0]});
    return mode_e'(m);
  endfunction

  function automatic logic is_periodic(input mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       gate_i,
  input  logic       load_i,
  input  logic [2:0] mode_i,
  output mode_e      mode_o,
  output logic       restart_o,
  output logic       adv_o
);
  mode_e mode_q;
  logic  gate_q;
  logic  gate_rise, retrig, gated;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_TERM;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (load_i) mode_q <= fold_mode(mode_i);
    end
  end

  always_comb begin
    gate_rise = gate_i & ~gate_q;
    retrig    = (mode_q != M_TERM) && (mode_q != M_SWSTROBE);
    gated     = ~retrig;
    restart_o = !load_i && gate_rise && retrig;
    adv_o     = !load_i && !restart_o && tick_i && (gated ? gate_i : 1'b1);
  end

  assign mode_o = mode_q;

  // R4: a gate edge never restarts a gated mode
  a_r4_no_restart_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_TERM || mode_q == M_SWSTROBE) |-> !restart_o);
  // R3: low gate blocks counting in gated modes
  a_r3_gate_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == M_TERM || mode_q == M_SWSTROBE) && !gate_i) |-> !adv_o);
endmodule

// File: rtl/pit_phase.sv
module pit_phase
  import pit_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int PH_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             restart_i,
  input  logic             adv_i,
  input  mode_e            mode_i,
  output logic [PH_W-1:0]  init_o,
  output logic [PH_W-1:0]  ph_o,
  output logic             done_o,
  output logic             pulse_o
);
  localparam logic [PH_W-1:0] FULL = PH_W'(1) << CNT_W;

  logic [PH_W-1:0] init_q, ph_q, ph_inc;
  logic            done_q, pulse_q, hit;

  assign ph_inc = ph_q + PH_W'(1);
  assign hit    = (ph_inc == init_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= FULL;
      ph_q    <= '0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (load_i) begin
      init_q  <= (load_val_i == '0) ? FULL : {1'b0, load_val_i};
      ph_q    <= '0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (restart_i) begin
      ph_q    <= '0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (adv_i) begin
      if (is_periodic(mode_i)) begin
        ph_q    <= hit ? '0 : ph_inc;
        pulse_q <= hit && (mode_i == M_RATE);
      end else begin
        ph_q    <= ph_inc;
        pulse_q <= hit && !done_q;
        if (hit) done_q <= 1'b1;
      end
    end
  end

  assign init_o  = init_q;
  assign ph_o    = ph_q;
  assign done_o  = done_q;
  assign pulse_o = pulse_q;

  // R5: periodic phase stays inside the period
  a_r5_phase_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_periodic(mode_i) && !load_i |=> (ph_q < init_q));
  // R1: initial count is never zero
  a_r1_init_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q != '0);
endmodule

// File: rtl/pit_view.sv
module pit_view
  import pit_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int PH_W = CNT_W + 1
) (
  input  mode_e            mode_i,
  input  logic [PH_W-1:0]  init_i,
  input  logic [PH_W-1:0]  ph_i,
  input  logic             done_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  logic [PH_W-1:0] half, sub, diff;

  always_comb begin
    half = (init_i + PH_W'(1)) >> 1;
    sub  = ph_i;
    if (mode_i == M_SQUARE) sub = (ph_i < half) ? (ph_i << 1) : ((ph_i - half) << 1);
    diff = init_i - sub;
    count_o = diff[CNT_W-1:0];
    unique case (mode_i)
      M_TERM, M_ONESHOT:                out_o = done_i;
      M_SQUARE:                         out_o = (ph_i < half);
      M_RATE, M_SWSTROBE, M_HWSTROBE:   out_o = pulse_i;
      default:                          out_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int PH_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [2:0]       mode_i,
  input  logic             bcd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  mode_e           mode_q;
  logic            restart, adv, done, pulse;
  logic [PH_W-1:0] init, ph;

  pit_ctrl u_ctrl (
    .clk_i, .rst_ni, .tick_i, .gate_i, .load_i, .mode_i,
    .mode_o(mode_q), .restart_o(restart), .adv_o(adv)
  );

  pit_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i, .rst_ni, .load_i, .load_val_i,
    .restart_i(restart), .adv_i(adv), .mode_i(mode_q),
    .init_o(init), .ph_o(ph), .done_o(done), .pulse_o(pulse)
  );

  pit_view #(.CNT_W(CNT_W)) u_view (
    .mode_i(mode_q), .init_i(init), .ph_i(ph), .done_i(done), .pulse_i(pulse),
    .count_o, .out_o
  );

  a_r1_load_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(load_val_i)));
  a_r10_bcd_binary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && bcd_i) |=> (count_o == $past(load_val_i)));
  a_r3_out_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_TERM && out_o && !load_i) |=> out_o);
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !is_periodic(mode_q)) |=> (count_o == $past(count_o) - CNT_W'(1)));
  a_r8_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_HWSTROBE && out_o && tick_i && !load_i) |=> !out_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !restart) |=> ($stable(count_o) && $stable(out_o)));
endmodule

// File: tb/sim_pit_channel.sv
module sim_pit_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, gate = 1'b0, load = 1'b0, bcd = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode = '0;
  logic [15:0] count;
  logic        out;

  int checks = 0, fails = 0;
  bit finished = 0;

  int    q_cnt[$];
  bit    q_out[$];
  string q_tag[$];

  // reference state
  int md = 0, init = 65536, d = 0;
  bit gprev = 0;

  always #2 clk = ~clk;

  pit_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .gate_i(gate), .load_i(load),
    .load_val_i(load_val), .mode_i(mode), .bcd_i(bcd), .count_o(count), .out_o(out)
  );

  function automatic int exp_count();
    int p, h, p2;
    p = d % init;
    h = (init + 1) / 2;
    case (md)
      2: return (init - p) & 16'hFFFF;
      3: begin
        p2 = (p < h) ? p : p - h;
        return (init - 2 * p2) & 16'hFFFF;
      end
      default: return (init - d) & 16'hFFFF;
    endcase
  endfunction

  function automatic bit exp_out();
    case (md)
      0, 1: return d >= init;
      2: return (d > 0) && (d % init == 0);
      3: return (d % init) < ((init + 1) / 2);
      default: return d == init;
    endcase
  endfunction

  task automatic step(input bit tk, input bit gt, input bit ld, input logic [15:0] v,
                      input logic [2:0] m, input bit bc, input string tag);
    @(negedge clk);
    tick = tk; gate = gt; load = ld; load_val = v; mode = m; bcd = bc;
    if (ld) begin
      md = m[1] ? int'(m[1:0]) : int'(m);
      init = (v == 0) ? 65536 : int'(v);
      d = 0;
    end else if (gt && !gprev && (md == 1 || md == 2 || md == 3 || md == 5)) begin
      d = 0;
    end else if (tk && ((md == 0 || md == 4) ? gt : 1'b1)) begin
      d++;
    end
    gprev = gt;
    q_cnt.push_back(exp_count());
    q_out.push_back(exp_out());
    q_tag.push_back(tag);
  endtask

  task automatic run(input int n, input bit tk, input bit gt, input string tag);
    for (int i = 0; i < n; i++) step(tk, gt, 0, 16'h0, 3'd0, 0, tag);
  endtask

  task automatic ld(input logic [15:0] v, input logic [2:0] m, input bit gt, input string tag);
    step(1, gt, 1, v, m, 0, tag);
  endtask

  // monitor: compare after each edge
  always begin
    @(posedge clk);
    #1;
    if (q_cnt.size() > 0) begin
      int    ec;
      bit    eo;
      string t;
      ec = q_cnt.pop_front(); eo = q_out.pop_front(); t = q_tag.pop_front();
      checks++;
      if (count !== ec[15:0] || out !== eo) begin
        fails++;
        $display("FAIL %s: count=%h out=%b expected count=%h out=%b", t, count, out, ec[15:0], eo);
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (count !== 16'h0000 || out !== 1'b0) begin
      fails++;
      $display("FAIL R2: count=%h out=%b expected count=0000 out=0", count, out);
    end
    gprev = 0;
    // R1 / R3 mode 0
    ld(16'd5, 3'd0, 1, "R1");
    run(8, 1, 1, "R3");
    run(3, 1, 0, "R3");
    run(2, 1, 1, "R3");
    ld(16'd0, 3'd0, 1, "R1");
    run(3, 1, 1, "R3");
    // R11 sparse ticks
    ld(16'd6, 3'd0, 1, "R1");
    for (int i = 0; i < 8; i++) step(i[0], 1, 0, 16'h0, 3'd0, 0, "R11");
    // R4 mode 1
    ld(16'd4, 3'd1, 0, "R1");
    run(2, 1, 0, "R4");
    run(6, 1, 1, "R4");
    run(1, 1, 0, "R4");
    run(3, 1, 1, "R4");
    // R5 mode 2
    ld(16'd3, 3'd2, 1, "R1");
    run(10, 1, 1, "R5");
    run(1, 1, 0, "R5");
    run(4, 1, 1, "R5");
    run(3, 0, 1, "R11");
    ld(16'd1, 3'd2, 1, "R1");
    run(3, 1, 1, "R5");
    // R6 mode 3
    ld(16'd5, 3'd3, 1, "R1");
    run(12, 1, 1, "R6");
    ld(16'd4, 3'd3, 1, "R1");
    run(5, 1, 1, "R6");
    run(1, 1, 0, "R6");
    run(4, 1, 1, "R6");
    // R7 mode 4
    ld(16'd3, 3'd4, 1, "R1");
    run(5, 1, 1, "R7");
    ld(16'd3, 3'd4, 1, "R1");
    run(2, 1, 1, "R7");
    run(2, 1, 0, "R7");
    run(1, 1, 1, "R7");
    run(2, 1, 0, "R7");
    run(2, 1, 1, "R7");
    // R8 mode 5
    ld(16'd3, 3'd5, 1, "R1");
    run(2, 1, 1, "R8");
    run(1, 1, 0, "R8");
    run(6, 1, 1, "R8");
    // R9 aliases
    ld(16'd3, 3'd6, 1, "R9");
    run(7, 1, 1, "R9");
    ld(16'd5, 3'd7, 1, "R9");
    run(7, 1, 1, "R9");
    // R10 bcd flag
    step(1, 1, 1, 16'h0010, 3'd0, 1, "R10");
    run(3, 1, 1, "R10");
    // drain
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule